// File: doc/BRIEF.md
# Third-Order Single-Bit Noise-Shaping Modulator with Switchable Resonator

This block turns a stream of signed fixed-point samples, one per clock, into a stream of single bits whose low-frequency content follows the input. It is a third-order loop of three saturating integrators in feedback form. The output bit is the sign of the last integrator. The bit is fed back as plus or minus full scale into the input of every integrator. All loop gains are arithmetic right shifts, so the loop has no multipliers.

A one-bit mode input switches a small negative feedback from the third integrator into the second integrator's input. The gain of that feedback is a right shift of seven. When the mode is 0 the feedback is absent and all noise-transfer zeros sit at DC, which suits narrower signal bands. When the mode is 1 one pair of zeros moves off DC, which suits bands roughly twice as wide. The mode is registered on the clock, so software can change it at any time without disturbing the loop state.

Top module: `dsm_cifb3`

## Requirements
- R1: `bitOut` is 1 when the third integrator is zero or positive and 0 when it is negative. The value fed back is +2^(W-1) for a 1 and -2^(W-1) for a 0.
- R2: On each clock, with v the fed-back value and floor-rounding arithmetic right shifts, the integrators update as follows: i1 += (x - v) >> A1, i2 += (i1 - v) >> A2 - r, i3 += (i2 - v) >> A3. All right-hand sides use the values from before the edge.
- R3: Each integrator is IW bits wide and saturates to the range [-2^(IW-1), 2^(IW-1)-1] instead of wrapping.
- R4: The term r equals i3 >> G (default G = 7) when the registered mode is 1, and 0 when the registered mode is 0.
- R5: `modeWide` is sampled on each clock and used in the following cycle's update. A change of mode leaves the integrator values untouched.
- R6: Synchronous reset `rst` (active high) clears all three integrators and the registered mode. In the cycle after reset, `bitOut` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| modeWide | input | 1 | 1 enables the resonator feedback term |
| sampleIn | input | W | Signed two's-complement input sample |
| bitOut | output | 1 | Modulator output bit |

## Verification
On every cycle, assertions check that no integrator wraps when its value and its increment share a sign, and that a saturated integrator stays at its limit while pushed further. They also check that the registered mode follows the mode input with one cycle of delay, and that reset leaves the output at 1. Only the bench scenarios can show that the bit stream matches the update equations exactly. These scenarios cover constant and swept inputs, both modes, mode changes in the middle of a run, and resets in the middle of a run.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  typedef struct packed {
    logic resEn;  // registered mode: resonator term active
    logic fbPos;  // feedback polarity: 1 selects +full scale
  } loopStrobes_t;
endpackage

// File: rtl/dsm_ctrl.sv
module dsm_ctrl
  import dsm_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         modeIn,
  input  logic         bitIn,
  output loopStrobes_t strobes
);
  logic modeQ;

  always_ff @(posedge clk) begin
    if (rst) modeQ <= 1'b0;
    else     modeQ <= modeIn;
  end

  always_comb begin
    strobes.resEn = modeQ;
    strobes.fbPos = bitIn;
  end

  // R5: mode takes effect one clock after it is presented
  assert_mode_latency_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (strobes.resEn == $past(modeIn)));
endmodule

// File: rtl/dsm_datapath.sv
module dsm_datapath
  import dsm_pkg::*;
#(
  parameter int W  = 12,
  parameter int IW = 18,
  parameter int A1 = 3,
  parameter int A2 = 2,
  parameter int A3 = 1,
  parameter int G  = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] sampleIn,
  input  loopStrobes_t        strobes,
  output logic                bitOut
);
  localparam int SW = IW + 3;
  localparam int NST = 3;
  typedef logic signed [SW-1:0] wide_t;
  localparam wide_t MAXW = wide_t'((64'sd1 <<< (IW-1)) - 1);
  localparam wide_t MINW = -wide_t'(64'sd1 <<< (IW-1));
  localparam wide_t FSW  = wide_t'(64'sd1 <<< (W-1));
  localparam wide_t ZEROW = wide_t'(0);

  logic signed [IW-1:0] acc [NST];
  wide_t accW [NST];
  wide_t incr [NST];
  wide_t fbVal, xW, resTerm;

  always_comb begin
    for (int k = 0; k < NST; k++) accW[k] = wide_t'(acc[k]);
    xW      = wide_t'(sampleIn);
    fbVal   = strobes.fbPos ? FSW : -FSW;
    resTerm = strobes.resEn ? (accW[2] >>> G) : ZEROW;
    incr[0] = (xW - fbVal) >>> A1;
    incr[1] = ((accW[0] - fbVal) >>> A2) - resTerm;
    incr[2] = (accW[1] - fbVal) >>> A3;
  end

  assign bitOut = ~acc[NST-1][IW-1];

  for (genvar i = 0; i < NST; i++) begin : gStage
    wide_t sum;
    logic signed [IW-1:0] nextVal;
    always_comb begin
      sum = accW[i] + incr[i];
      if (sum > MAXW)      nextVal = MAXW[IW-1:0];
      else if (sum < MINW) nextVal = MINW[IW-1:0];
      else                 nextVal = sum[IW-1:0];
    end
    always_ff @(posedge clk) begin
      if (rst) acc[i] <= '0;
      else     acc[i] <= nextVal;
    end

    // R3: same-sign accumulation never flips the sign
    assert_no_wrap_pos_R3: assert property (@(posedge clk) disable iff (rst)
      (!acc[i][IW-1] && !incr[i][SW-1]) |=> !acc[i][IW-1]);
    assert_no_wrap_neg_R3: assert property (@(posedge clk) disable iff (rst)
      (acc[i][IW-1] && incr[i][SW-1]) |=> acc[i][IW-1]);
    // R3: a saturated integrator pushed further stays at its limit
    assert_sat_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (accW[i] == MAXW && !incr[i][SW-1]) |=> (accW[i] == MAXW));
  end
endmodule

// File: rtl/dsm_cifb3.sv
module dsm_cifb3
  import dsm_pkg::*;
#(
  parameter int W  = 12,
  parameter int IW = 18,
  parameter int A1 = 3,
  parameter int A2 = 2,
  parameter int A3 = 1,
  parameter int G  = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                modeWide,
  input  logic signed [W-1:0] sampleIn,
  output logic                bitOut
);
  loopStrobes_t strobes;

  dsm_ctrl uCtrl (
    .clk(clk), .rst(rst), .modeIn(modeWide), .bitIn(bitOut), .strobes(strobes)
  );

  dsm_datapath #(.W(W), .IW(IW), .A1(A1), .A2(A2), .A3(A3), .G(G)) uPath (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .strobes(strobes), .bitOut(bitOut)
  );

  // R6: reset leaves the output at 1
  assert_reset_out_R6: assert property (@(posedge clk)
    rst |=> bitOut);
endmodule

// File: tb/sim_dsm_cifb3.sv
module sim_dsm_cifb3;
  localparam int W = 12, IW = 18, A1 = 3, A2 = 2, A3 = 1, G = 7;
  localparam longint FS = 64'sd1 <<< (W-1);
  localparam longint MAXV = (64'sd1 <<< (IW-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (IW-1));

  logic clk = 1'b0, rst = 1'b1, modeWide = 1'b0;
  logic signed [W-1:0] sampleIn = '0;
  logic bitOut;
  int nChecks = 0, nFails = 0;
  longint m1 = 0, m2 = 0, m3 = 0;
  logic mq = 1'b0;

  always #2.5 clk = ~clk;

  dsm_cifb3 #(.W(W), .IW(IW), .A1(A1), .A2(A2), .A3(A3), .G(G)) u0 (
    .clk(clk), .rst(rst), .modeWide(modeWide), .sampleIn(sampleIn), .bitOut(bitOut)
  );

  function automatic longint sat(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: bitOut=%b expected %b (check %0d)", req, act, exp, nChecks);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input longint x, input logic c, input logic r, input string req);
    longint v, n1, n2, n3;
    sampleIn = x[W-1:0];
    modeWide = c;
    rst = r;
    @(posedge clk);
    if (r) begin
      m1 = 0; m2 = 0; m3 = 0; mq = 1'b0;
    end else begin
      v  = (m3 >= 0) ? FS : -FS;
      n1 = sat(m1 + ((x - v) >>> A1));
      n2 = sat(m2 + ((m1 - v) >>> A2) - (mq ? (m3 >>> G) : 64'sd0));
      n3 = sat(m3 + ((m2 - v) >>> A3));
      m1 = n1; m2 = n2; m3 = n3; mq = c;
    end
    @(negedge clk);
    check(bitOut, (m3 >= 0), req);
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog: run did not end (expected completion)");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    longint dcVals[8] = '{0, 1, -1, 300, -700, 1500, -1900, 2047};
    @(negedge clk);
    // R6: reset state
    step(0, 1'b1, 1'b1, "R6");
    step(0, 1'b1, 1'b1, "R6");
    // R1 R2 R4: constant inputs in both modes
    for (int c = 0; c < 2; c++) begin
      foreach (dcVals[k]) begin
        step(0, c[0], 1'b1, "R6");
        for (int t = 0; t < 1200; t++) step(dcVals[k], c[0], 1'b0, c ? "R4" : "R2");
      end
    end
    // R3: full-scale negative drive saturates integrators
    step(0, 1'b0, 1'b1, "R6");
    for (int t = 0; t < 1500; t++) step(-2048, 1'b0, 1'b0, "R3");
    for (int t = 0; t < 1500; t++) step(-2048, 1'b1, 1'b0, "R3");
    // R2 R4: triangle sweeps in both modes
    for (int c = 0; c < 2; c++) begin
      step(0, c[0], 1'b1, "R6");
      for (int t = 0; t < 4000; t++) begin
        int ph = t % 400;
        longint x = (ph < 200) ? (-1800 + 18 * ph) : (1800 - 18 * (ph - 200));
        step(x, c[0], 1'b0, c ? "R4" : "R2");
      end
    end
    // R5: mode toggled mid-run without reset
    for (int t = 0; t < 4000; t++) begin
      longint x = ((t / 50) % 2 == 0) ? 900 : -1300;
      step(x, ((t / 37) % 2) == 1, 1'b0, "R5");
    end
    // R6: reset in mid-run clears state, mode held high in reset
    for (int t = 0; t < 300; t++) step(1700, 1'b1, 1'b0, "R6");
    step(1700, 1'b1, 1'b1, "R6");
    for (int t = 0; t < 500; t++) step(-400, 1'b1, 1'b0, "R6");
    // R1: single cycles around tiny inputs from fresh state
    step(0, 1'b0, 1'b1, "R6");
    for (int t = 0; t < 64; t++) step(t - 32, 1'b0, 1'b0, "R1");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule